// File: doc/BRIEF.md
# Byte-Lane Synchronous SRAM with Selectable Read Latency

This block is a synchronous static memory of parameterizable depth. Its word is made of two byte lanes of nine bits each. Address, data and every control are taken on the rising clock edge. A write may store one lane, the other lane, or the whole word. A global-write strobe stores the whole word and overrides the per-lane selection. Three chip enables must all be active before a cycle counts as an access. A synchronous data enable decides whether the data pins are taken in that cycle or the last captured word is used again.

A static mode input picks the read path. In flow-through mode the word read from the array reaches the output in the cycle after the address edge. In pipelined mode the word passes through one more output register and appears a cycle later. The flag that says whether the output holds valid read data is delayed by the same amount. A deselect or a write therefore takes the output off with the same delay as a read. In pipelined mode the output stays on for the full cycle after a deselect and turns off only after the second edge. A separate output enable gates the output drive combinationally and has no effect on anything stored.

Top module: `sram_bytewrite`

## Requirements
- R1: An access takes place only when `ce1N` is 0, `ce2` is 1 and `ce3N` is 0 at the rising edge. Any other combination writes nothing and produces no valid read data.
- R2: When `gwN` is 0 in a selected cycle, both lanes of the word at `addr` are written, whatever `bweN` and `bwN` are.
- R3: When `gwN` is 1, lane i is written only if `bweN` is 0 and `bwN[i]` is 0. Lane 0 is bits 8:0 and lane 1 is bits 17:9. A lane that is not written keeps its content. A selected cycle that writes no lane is a read.
- R4: When `deN` is 0 at an edge, `dataIn` is captured and used for that cycle's write. When `deN` is 1, a write stores the word captured at the most recent edge with `deN` at 0 (zero after reset).
- R5: With `flowThru` at 1, a read accepted at edge k gives `outValid` 1 and the stored word in the cycle after edge k.
- R6: With `flowThru` at 0, a read accepted at edge k gives `outValid` 1 and the word in the cycle after edge k+1. If a write hits the same address at edge k+1, the read still returns the word as it was before that write.
- R7: A cycle that is not a read (deselected or a write) drives `outValid` to 0 with the same delay as a read: after one edge in flow-through mode, and after two edges in pipelined mode, so that in pipelined mode a deselect that follows a read leaves the output on for one full cycle.
- R8: `outDrive` equals `outValid` AND NOT `oeN`, combinationally. `dataOut` is zero whenever `outDrive` is 0. `oeN` changes neither the stored data nor the read pipeline.
- R9: While `rstN` is 0, `outValid`, `outDrive` and `dataOut` are 0, and the captured data word is cleared.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Asynchronous active-low reset |
| flowThru | input | 1 | Static read mode: 1 flow-through, 0 pipelined |
| ce1N | input | 1 | Chip enable, active low |
| ce2 | input | 1 | Chip enable, active high |
| ce3N | input | 1 | Chip enable, active low |
| gwN | input | 1 | Global write, active low |
| bweN | input | 1 | Byte-write enable, active low |
| bwN | input | 2 | Per-lane write select, active low |
| deN | input | 1 | Data enable, active low |
| oeN | input | 1 | Asynchronous output enable, active low |
| addr | input | ADDR_W | Word address |
| dataIn | input | 18 | Write data |
| dataOut | output | 18 | Read data, zero when not driven |
| outValid | output | 1 | Read data valid at the selected latency |
| outDrive | output | 1 | Output drivers on |

## Verification
The hardest case to reach from the ports is a pipelined read followed at the very next edge by a write to the same address. The array changes while the read word is still on its way to the output register. The stimulus issues a read of an address and then a global write to it with new data, and the scoreboard expects the old word one cycle later. The same sequence is run in both modes, each mode after its own reset. It includes deselects placed straight after reads, so the one-cycle hold in pipelined mode is checked at the output valid flag.

// File: rtl/sram_pkg.sv
package sram_pkg;
  localparam int LANES = 2;

  typedef struct packed {
    logic [LANES-1:0] laneWe;   // per-lane write strobe for this edge
    logic             loadData; // capture dataIn at this edge
    logic             rdAccept; // selected read at this edge
    logic             outLoad;  // pipelined output register load
  } strobeT;
endpackage

// File: rtl/sram_ctrl.sv
module sram_ctrl
  import sram_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             flowThru,
  input  logic             ce1N,
  input  logic             ce2,
  input  logic             ce3N,
  input  logic             gwN,
  input  logic             bweN,
  input  logic [LANES-1:0] bwN,
  input  logic             deN,
  output strobeT           stb,
  output logic             outValid
);
  logic             chipSel;
  logic [LANES-1:0] laneReq;
  logic             rdStage1;
  logic             rdStage2;

  assign chipSel = !ce1N && ce2 && !ce3N;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign laneReq[i] = !gwN || (!bweN && !bwN[i]);
  end

  assign stb.laneWe   = chipSel ? laneReq : '0;
  assign stb.loadData = !deN;
  assign stb.rdAccept = chipSel && (laneReq == '0);
  assign stb.outLoad  = rdStage1;

  // read and deselect travel through the same stages
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdStage1 <= 1'b0;
      rdStage2 <= 1'b0;
    end else begin
      rdStage1 <= stb.rdAccept;
      rdStage2 <= rdStage1;
    end
  end

  assign outValid = flowThru ? rdStage1 : rdStage2;

  a_r1_no_access_flow: assert property (@(posedge clk) disable iff (!rstN)
    (flowThru && !chipSel) |=> !outValid);
  a_r5_flow_latency: assert property (@(posedge clk) disable iff (!rstN)
    (flowThru && stb.rdAccept) |=> outValid);
  a_r6_pipe_latency: assert property (@(posedge clk) disable iff (!rstN)
    (!flowThru && stb.rdAccept) |=> ##1 outValid);
  a_r7_flow_off: assert property (@(posedge clk) disable iff (!rstN)
    (flowThru && !stb.rdAccept) |=> !outValid);
  a_r7_pipe_off: assert property (@(posedge clk) disable iff (!rstN)
    (!flowThru && !stb.rdAccept) |=> ##1 !outValid);
  a_r7_pipe_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!flowThru && stb.rdAccept) |=> (!stb.rdAccept |=> outValid));
endmodule

// File: rtl/sram_datapath.sv
module sram_datapath
  import sram_pkg::*;
#(
  parameter int DEPTH  = 256,
  parameter int LANE_W = 9,
  localparam int ADDR_W = $clog2(DEPTH),
  localparam int WORD_W = LANES * LANE_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              flowThru,
  input  strobeT            stb,
  input  logic [ADDR_W-1:0] addr,
  input  logic [WORD_W-1:0] dataIn,
  output logic [WORD_W-1:0] rdData
);
  logic [WORD_W-1:0] mem [DEPTH];
  logic [WORD_W-1:0] dataReg;
  logic [WORD_W-1:0] outReg;
  logic [ADDR_W-1:0] addrReg;
  logic [WORD_W-1:0] wrData;

  assign wrData = stb.loadData ? dataIn : dataReg;

  always_ff @(posedge clk) begin
    for (int i = 0; i < LANES; i++) begin
      if (stb.laneWe[i]) mem[addr][i*LANE_W +: LANE_W] <= wrData[i*LANE_W +: LANE_W];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dataReg <= '0;
      addrReg <= '0;
      outReg  <= '0;
    end else begin
      if (stb.loadData) dataReg <= dataIn;
      if (stb.rdAccept) addrReg <= addr;
      if (stb.outLoad)  outReg  <= mem[addrReg];
    end
  end

  assign rdData = flowThru ? mem[addrReg] : outReg;

  for (genvar g = 0; g < LANES; g++) begin : g_chk
    a_r3_lane_kept: assert property (@(posedge clk) disable iff (!rstN)
      !stb.laneWe[g] |=>
        (mem[$past(addr)][g*LANE_W +: LANE_W] === $past(mem[addr][g*LANE_W +: LANE_W])));
  end

  a_r4_held_word: assert property (@(posedge clk) disable iff (!rstN)
    !stb.loadData |=> (dataReg == $past(dataReg)));
endmodule

// File: rtl/sram_bytewrite.sv
module sram_bytewrite
  import sram_pkg::*;
#(
  parameter int DEPTH  = 256,
  parameter int LANE_W = 9,
  localparam int ADDR_W = $clog2(DEPTH),
  localparam int WORD_W = LANES * LANE_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              flowThru,
  input  logic              ce1N,
  input  logic              ce2,
  input  logic              ce3N,
  input  logic              gwN,
  input  logic              bweN,
  input  logic [LANES-1:0]  bwN,
  input  logic              deN,
  input  logic              oeN,
  input  logic [ADDR_W-1:0] addr,
  input  logic [WORD_W-1:0] dataIn,
  output logic [WORD_W-1:0] dataOut,
  output logic              outValid,
  output logic              outDrive
);
  strobeT            stb;
  logic [WORD_W-1:0] rdData;

  sram_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .flowThru(flowThru),
    .ce1N(ce1N), .ce2(ce2), .ce3N(ce3N),
    .gwN(gwN), .bweN(bweN), .bwN(bwN), .deN(deN),
    .stb(stb), .outValid(outValid)
  );

  sram_datapath #(.DEPTH(DEPTH), .LANE_W(LANE_W)) u_dp (
    .clk(clk), .rstN(rstN), .flowThru(flowThru), .stb(stb),
    .addr(addr), .dataIn(dataIn), .rdData(rdData)
  );

  assign outDrive = outValid && !oeN;
  assign dataOut  = outDrive ? rdData : '0;

  a_r8_oe_off: assert property (@(posedge clk) disable iff (!rstN)
    oeN |-> (!outDrive && dataOut == '0));
  a_r9_reset_quiet: assert property (@(posedge clk)
    !rstN |-> (!outValid && !outDrive));
endmodule

// File: tb/tb_sram_bytewrite.sv
module tb_sram_bytewrite;
  localparam int DEPTH  = 256;
  localparam int LANE_W = 9;
  localparam int ADDR_W = 8;
  localparam int WORD_W = 18;
  localparam logic [2:0] CE_ON  = 3'b010; // {ce3N, ce2, ce1N}
  localparam logic [2:0] CE_OFF = 3'b011;

  logic clk = 1'b0, rstN = 1'b0, flowThru = 1'b1;
  logic ce1N = 1'b1, ce2 = 1'b1, ce3N = 1'b0;
  logic gwN = 1'b1, bweN = 1'b1, deN = 1'b1, oeN = 1'b0;
  logic [1:0] bwN = 2'b11;
  logic [ADDR_W-1:0] addr = '0;
  logic [WORD_W-1:0] dataIn = '0;
  logic [WORD_W-1:0] dataOut;
  logic outValid, outDrive;

  always #5 clk = ~clk;

  sram_bytewrite #(.DEPTH(DEPTH), .LANE_W(LANE_W)) dut (
    .clk(clk), .rstN(rstN), .flowThru(flowThru),
    .ce1N(ce1N), .ce2(ce2), .ce3N(ce3N),
    .gwN(gwN), .bweN(bweN), .bwN(bwN), .deN(deN), .oeN(oeN),
    .addr(addr), .dataIn(dataIn),
    .dataOut(dataOut), .outValid(outValid), .outDrive(outDrive)
  );

  typedef struct { int due; logic [WORD_W-1:0] data; } expT;
  expT expQ[$];
  logic [WORD_W-1:0] mdl [DEPTH];
  logic [WORD_W-1:0] mdlData = '0;
  int edgeCnt = 0;
  int checks = 0, errors = 0;

  always @(posedge clk) edgeCnt++;

  task automatic check(input bit ok, input string req,
                       input logic [WORD_W-1:0] act, input logic [WORD_W-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h (edge %0d)", req, act, exp, edgeCnt);
    end
  endtask

  // driver: applies one cycle and pushes the expected read result
  task automatic cyc(input logic [2:0] ce, input bit gwn, input bit bwen, input bit [1:0] bwn,
                     input bit den, input int a, input logic [WORD_W-1:0] d, input bit oen);
    logic [1:0] req;
    logic [WORD_W-1:0] wd;
    @(negedge clk);
    {ce3N, ce2, ce1N} = ce;
    gwN = gwn; bweN = bwen; bwN = bwn; deN = den; oeN = oen;
    addr = ADDR_W'(a); dataIn = d;
    for (int i = 0; i < 2; i++) req[i] = !gwn || (!bwen && !bwn[i]);   // R2 / R3 rules
    wd = !den ? d : mdlData;                                            // R4 rule
    if (ce == CE_ON) begin                                              // R1 rule
      if (req != 2'b00) begin
        for (int i = 0; i < 2; i++)
          if (req[i]) mdl[a][i*LANE_W +: LANE_W] = wd[i*LANE_W +: LANE_W];
      end else begin
        expQ.push_back('{edgeCnt + 1 + (flowThru ? 0 : 1), mdl[a]});   // R5 / R6 latency
      end
    end
    if (!den) mdlData = d;
  endtask

  task automatic rd(input int a, input bit oen = 1'b0);
    cyc(CE_ON, 1'b1, 1'b1, 2'b11, 1'b1, a, 18'h0, oen);
  endtask
  task automatic wr(input int a, input logic [WORD_W-1:0] d, input bit gwn,
                    input bit bwen, input bit [1:0] bwn, input bit den);
    cyc(CE_ON, gwn, bwen, bwn, den, a, d, 1'b0);
  endtask
  task automatic idle(input bit oen = 1'b0);
    cyc(CE_OFF, 1'b1, 1'b1, 2'b11, 1'b1, 0, 18'h0, oen);
  endtask

  // monitor: pops expected items as they fall due, checks quiet cycles otherwise
  initial begin : mon
    bit expV;
    logic [WORD_W-1:0] expD;
    forever begin
      @(negedge clk);
      #1;
      if (rstN) begin
        expV = (expQ.size() > 0) && (expQ[0].due == edgeCnt);
        expD = expV ? expQ[0].data : '0;
        check(outValid == expV, "R5/R6/R7 outValid", 18'(outValid), 18'(expV));
        check(outDrive == (expV && !oeN), "R8 outDrive", 18'(outDrive), 18'(expV && !oeN));
        if (expV && !oeN) check(dataOut === expD, "R2/R3/R4/R5/R6 read data", dataOut, expD);
        else              check(dataOut == '0, "R8 dataOut gated", dataOut, '0);
        if (expV) void'(expQ.pop_front());
      end
    end
  end

  task automatic runPhase(input bit ft);
    @(negedge clk);
    rstN = 1'b0;
    flowThru = ft;
    expQ.delete();
    mdlData = '0;
    repeat (2) @(negedge clk);
    #1;
    check(!outValid && !outDrive, "R9 reset outputs", 18'({outValid, outDrive}), 18'h0);
    check(dataOut == '0, "R9 reset data", dataOut, '0);
    rstN = 1'b1;
    // R9: captured word cleared, so a write with deN high stores zero
    wr(5, 18'h3FFFF, 1'b0, 1'b1, 2'b11, 1'b1);
    rd(5);
    // R2: global write overrides bwN/bweN
    wr(10, 18'h2A5A5, 1'b0, 1'b1, 2'b11, 1'b0);
    rd(10);
    // R3: lane 0 only, lane 1 only, no lane (read)
    wr(10, 18'h15555, 1'b1, 1'b0, 2'b10, 1'b0);
    rd(10);
    wr(10, 18'h0F0F3, 1'b1, 1'b0, 2'b01, 1'b0);
    rd(10);
    wr(10, 18'h3FFFF, 1'b1, 1'b1, 2'b00, 1'b0);
    // R1: each chip enable inactive in turn, write must not land
    cyc(3'b011, 1'b0, 1'b1, 2'b11, 1'b0, 10, 18'h3FFFF, 1'b0);
    cyc(3'b000, 1'b0, 1'b1, 2'b11, 1'b0, 10, 18'h3FFFF, 1'b0);
    cyc(3'b110, 1'b0, 1'b1, 2'b11, 1'b0, 10, 18'h3FFFF, 1'b0);
    cyc(3'b000, 1'b1, 1'b1, 2'b11, 1'b1, 10, 18'h0, 1'b0);
    rd(10);
    // R4: captured word reused when deN is high
    wr(20, 18'h12345, 1'b0, 1'b1, 2'b11, 1'b0);
    wr(21, 18'h00001, 1'b0, 1'b1, 2'b11, 1'b1);
    rd(21);
    rd(20);
    // R6: back-to-back reads, then read followed by write to the same address
    rd(10); rd(20); rd(21);
    rd(20);
    wr(20, 18'h00777, 1'b0, 1'b1, 2'b11, 1'b0);
    rd(20);
    // R7: reads followed by deselect and by write
    rd(10); idle(); idle();
    rd(21); wr(30, 18'h2BCDE, 1'b0, 1'b1, 2'b11, 1'b0); idle();
    // R8: output enable high during valid and idle cycles
    rd(10, 1'b1); rd(20, 1'b1); rd(21); idle(1'b1); idle(); idle(1'b1);
    rd(30); idle(); idle(); idle();
    check(expQ.size() == 0, "R5/R6 queue drained", 18'(expQ.size()), 18'h0);
  endtask

  initial begin : watchdog
    #(200000 * 10);
    errors++;
    $display("FAIL watchdog R5/R6: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    runPhase(1'b1);
    runPhase(1'b0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule